// File: doc/BRIEF.md
# Double-Buffered Fine-Resolution PWM Generator

This block drives one pulse-width-modulated output. An 8-bit period timer sets the frame length. Two extra fine bits sit below the timer, so the duty cycle has 10-bit resolution.

The timer counts from zero up to a programmable period value, then restarts. The fine bits come from one of two sources:
- with a prescale of 1, a free-running 2-bit clock-phase counter;
- with a prescale of 4 or 16, two bits of the timer prescaler.

The output goes high at the start of each frame. It drops when the 10-bit position reaches the active duty value.

The duty value is written in two parts: an 8-bit coarse field and a 2-bit fine field. Software may write either part at any moment. Both parts land in a holding copy. The active copy takes the holding value only at a frame boundary, so a frame is never cut short or stretched by a write.

While the module enable is low, the following apply:
- the output is held low;
- all counters sit at zero;
- the active copy follows the holding copy.

When the enable is raised, the first frame therefore uses the value software programmed.

Top module: `pwm10_gen`

## Requirements
- R1: After reset, `pwm_out` is 0 and `active_hi` is 0.
- R2: The timer advances by one every 4×P clocks, where P is the prescale. A frame holds period_value+1 timer steps. A rising edge of `pwm_out` occurs only at a frame boundary, and successive frames start 4×P×(period_value+1) clocks apart.
- R3: Let D = {duty_hi, duty_lo}. Within a frame, `pwm_out` is high for exactly D×P clocks from the frame start, then low until the next frame.
- R4: A duty write during a frame does not change `active_hi` or the high time of that frame. The new value applies from the next frame boundary.
- R5: If D ≥ 4×(period_value+1), `pwm_out` stays high for the whole frame.
- R6: With D = 0, `pwm_out` never goes high.
- R7: `presc_sel` selects P: 2'b00 gives 1, 2'b01 gives 4, and 2'b10 or 2'b11 give 16.
- R8: While `mod_en` is 0, `pwm_out` is 0 from the next clock and all counters are cleared. After `mod_en` rises, the first rising edge of `pwm_out` comes 4×P×(period_value+1) clocks later, provided D > 0.
- R9: While `mod_en` is 0, `active_hi` takes the written coarse duty one clock after the write.
- R10: While `tmr_en` is 0 with `mod_en` at 1, the counters and `pwm_out` hold their values. Each held clock lengthens the current phase by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| mod_en | input | 1 | Module enable |
| tmr_en | input | 1 | Timer run enable |
| presc_sel | input | 2 | Prescale select (00:1, 01:4, 1x:16) |
| period_we | input | 1 | Period value write strobe |
| period_wdata | input | 8 | Period value (frame holds value+1 timer steps) |
| duty_hi_we | input | 1 | Coarse duty write strobe |
| duty_hi_wdata | input | 8 | Coarse duty, bits 9:2 of D |
| duty_lo_we | input | 1 | Fine duty write strobe |
| duty_lo_wdata | input | 2 | Fine duty, bits 1:0 of D |
| pwm_out | output | 1 | PWM output |
| active_hi | output | 8 | Read-only view of the active coarse duty |

## Verification
A fault in the prescaler or phase counter shows up at the port in two ways:
- frame starts move away from the 4×P×(period+1) grid;
- high times stop being a multiple of P.

Either becomes visible within the first frame after enable.

A broken double buffer changes `active_hi` mid-frame, or changes the high time of the frame in which the write happened. That is caught in that same frame.

A faulty end-of-frame compare shows in one of two ways:
- frames reach full duty where they should not;
- the output is never cleared when D exceeds the frame.

Either appears one frame after the offending duty is loaded.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

  typedef enum logic [1:0] {
    PRE_DIV1   = 2'b00,
    PRE_DIV4   = 2'b01,
    PRE_DIV16  = 2'b10,
    PRE_DIV16X = 2'b11
  } presc_e;

endpackage

// File: rtl/pwm10_prescale.sv
module pwm10_prescale
  import pwm10_pkg::*;
#(
  parameter int FINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic              tmr_en,
  input  logic [1:0]        presc_sel,
  output logic [FINE_W-1:0] fine_ext,
  output logic              fine_step,
  output logic              tmr_tick
);

  localparam int PC_W = 2 * FINE_W;

  logic [FINE_W-1:0] ph_q, ph_d;
  logic [PC_W-1:0]   pc_q, pc_d;
  logic [PC_W-1:0]   pc_mask;
  logic              run;
  logic              ph_wrap;
  logic              pc_lo_wrap;
  logic              pc_all_wrap;
  presc_e            mode;

  assign mode        = presc_e'(presc_sel);
  assign run         = mod_en & tmr_en;
  assign ph_wrap     = &ph_q;
  assign pc_lo_wrap  = &pc_q[FINE_W-1:0];
  assign pc_all_wrap = &pc_q;

  always_comb begin
    unique case (mode)
      PRE_DIV1: pc_mask = '0;
      PRE_DIV4: pc_mask = {{(PC_W-FINE_W){1'b0}}, {FINE_W{1'b1}}};
      default:  pc_mask = '1;
    endcase
  end

  // Fine step source, timer tick and the low extension, per prescale mode.
  always_comb begin
    unique case (mode)
      PRE_DIV1: begin
        fine_ext  = ph_q;
        fine_step = run;
        tmr_tick  = run & ph_wrap;
      end
      PRE_DIV4: begin
        fine_ext  = pc_q[FINE_W-1:0];
        fine_step = run & ph_wrap;
        tmr_tick  = run & ph_wrap & pc_lo_wrap;
      end
      default: begin
        fine_ext  = pc_q[PC_W-1:FINE_W];
        fine_step = run & ph_wrap & pc_lo_wrap;
        tmr_tick  = run & ph_wrap & pc_all_wrap;
      end
    endcase
  end

  always_comb begin
    ph_d = ph_q;
    pc_d = pc_q;
    if (!mod_en) begin
      ph_d = '0;
      pc_d = '0;
    end else if (tmr_en) begin
      ph_d = ph_q + FINE_W'(1);
      if (ph_wrap) pc_d = (pc_q + PC_W'(1)) & pc_mask;
      else         pc_d = pc_q & pc_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      pc_q <= '0;
    end else begin
      ph_q <= ph_d;
      pc_q <= pc_d;
    end
  end

  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !tmr_en) |=> ($stable(ph_q) && $stable(pc_q)))
    else $error("phase/prescale counters moved while timer stopped");

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (ph_q == '0 && pc_q == '0))
    else $error("counters not cleared while disabled");

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_tick |-> fine_step)
    else $error("timer tick without a fine step");

endmodule

// File: rtl/pwm10_timer.sv
module pwm10_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_en,
  input  logic             tmr_tick,
  input  logic [TMR_W-1:0] period,
  output logic [TMR_W-1:0] tmr,
  output logic             rollover
);

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             at_period;

  assign at_period = (tmr_q == period);
  assign rollover  = tmr_tick & at_period;
  assign tmr       = tmr_q;

  always_comb begin
    tmr_d = tmr_q;
    if (!mod_en)       tmr_d = '0;
    else if (rollover) tmr_d = '0;
    else if (tmr_tick) tmr_d = tmr_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assert_roll_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |=> (tmr_q == '0))
    else $error("timer did not restart after frame end");

  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !tmr_tick) |=> $stable(tmr_q))
    else $error("timer moved without a tick");

endmodule

// File: rtl/pwm10_duty.sv
module pwm10_duty #(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mod_en,
  input  logic                    load,
  input  logic                    hi_we,
  input  logic [TMR_W-1:0]        hi_wdata,
  input  logic                    lo_we,
  input  logic [FINE_W-1:0]       lo_wdata,
  output logic [TMR_W+FINE_W-1:0] hold_duty,
  output logic [TMR_W+FINE_W-1:0] act_duty
);

  localparam int DUTY_W = TMR_W + FINE_W;

  logic [TMR_W-1:0]  hold_hi_q, hold_hi_d;
  logic [FINE_W-1:0] hold_lo_q, hold_lo_d;
  logic [DUTY_W-1:0] act_q, act_d;
  logic              act_en;

  assign hold_duty = {hold_hi_q, hold_lo_q};
  assign act_duty  = act_q;
  assign act_en    = load | ~mod_en;

  always_comb begin
    hold_hi_d = hi_we ? hi_wdata : hold_hi_q;
    hold_lo_d = lo_we ? lo_wdata : hold_lo_q;
    act_d     = act_en ? {hold_hi_q, hold_lo_q} : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_hi_q <= '0;
      hold_lo_q <= '0;
      act_q     <= '0;
    end else begin
      hold_hi_q <= hold_hi_d;
      hold_lo_q <= hold_lo_d;
      act_q     <= act_d;
    end
  end

  assert_buffered_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !load) |=> $stable(act_q))
    else $error("active duty changed inside a frame");

  assert_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> (act_q == $past({hold_hi_q, hold_lo_q})))
    else $error("active duty not following holding copy while disabled");

endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen #(
  parameter int TMR_W  = 8,
  parameter int FINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mod_en,
  input  logic              tmr_en,
  input  logic [1:0]        presc_sel,
  input  logic              period_we,
  input  logic [TMR_W-1:0]  period_wdata,
  input  logic              duty_hi_we,
  input  logic [TMR_W-1:0]  duty_hi_wdata,
  input  logic              duty_lo_we,
  input  logic [FINE_W-1:0] duty_lo_wdata,
  output logic              pwm_out,
  output logic [TMR_W-1:0]  active_hi
);

  localparam int DUTY_W = TMR_W + FINE_W;

  logic [TMR_W-1:0]  period_q, period_d;
  logic [FINE_W-1:0] fine_ext;
  logic              fine_step;
  logic              tmr_tick;
  logic [TMR_W-1:0]  tmr;
  logic              rollover;
  logic [DUTY_W-1:0] hold_duty;
  logic [DUTY_W-1:0] act_duty;
  logic [DUTY_W-1:0] pos_next;
  logic              hit;
  logic              out_q, out_d;

  pwm10_prescale #(.FINE_W(FINE_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_en    (mod_en),
    .tmr_en    (tmr_en),
    .presc_sel (presc_sel),
    .fine_ext  (fine_ext),
    .fine_step (fine_step),
    .tmr_tick  (tmr_tick)
  );

  pwm10_timer #(.TMR_W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .mod_en   (mod_en),
    .tmr_tick (tmr_tick),
    .period   (period_q),
    .tmr      (tmr),
    .rollover (rollover)
  );

  pwm10_duty #(.TMR_W(TMR_W), .FINE_W(FINE_W)) u_duty (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_en    (mod_en),
    .load      (rollover),
    .hi_we     (duty_hi_we),
    .hi_wdata  (duty_hi_wdata),
    .lo_we     (duty_lo_we),
    .lo_wdata  (duty_lo_wdata),
    .hold_duty (hold_duty),
    .act_duty  (act_duty)
  );

  // Clear on the step that brings the position onto the duty value,
  // so the high time is exactly D fine units.
  assign pos_next = {tmr, fine_ext} + DUTY_W'(1);
  assign hit      = fine_step & (pos_next == act_duty);

  always_comb begin
    period_d = period_we ? period_wdata : period_q;
    out_d    = out_q;
    if (!mod_en)       out_d = 1'b0;
    else if (rollover) out_d = |hold_duty;
    else if (hit)      out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      out_q    <= 1'b0;
    end else begin
      period_q <= period_d;
      out_q    <= out_d;
    end
  end

  assign pwm_out   = out_q;
  assign active_hi = act_duty[DUTY_W-1:FINE_W];

  assert_disabled_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> !pwm_out)
    else $error("output high while disabled");

  assert_rise_at_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(rollover))
    else $error("output rose away from a frame boundary");

  assert_zero_duty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rollover && mod_en && hold_duty == '0) |=> !pwm_out)
    else $error("output high with zero duty");

  assert_stop_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && !tmr_en) |=> $stable(pwm_out))
    else $error("output changed while timer stopped");

endmodule

// File: tb/pwm10_gen_bench.sv
module pwm10_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mod_en, tmr_en;
  logic [1:0] presc_sel;
  logic       period_we, duty_hi_we, duty_lo_we;
  logic [7:0] period_wdata, duty_hi_wdata;
  logic [1:0] duty_lo_wdata;
  logic       pwm_out;
  logic [7:0] active_hi;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pwm10_gen u_pwm10_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .mod_en        (mod_en),
    .tmr_en        (tmr_en),
    .presc_sel     (presc_sel),
    .period_we     (period_we),
    .period_wdata  (period_wdata),
    .duty_hi_we    (duty_hi_we),
    .duty_hi_wdata (duty_hi_wdata),
    .duty_lo_we    (duty_lo_we),
    .duty_lo_wdata (duty_lo_wdata),
    .pwm_out       (pwm_out),
    .active_hi     (active_hi)
  );

  // {presc_sel, period, duty_hi, duty_lo}
  localparam logic [19:0] VEC [9] = '{
    {2'd0, 8'd4,    8'd1,    2'd2},
    {2'd0, 8'd9,    8'd10,   2'd3},
    {2'd1, 8'd3,    8'd2,    2'd1},
    {2'd2, 8'd1,    8'd1,    2'd0},
    {2'd0, 8'd0,    8'd0,    2'd1},
    {2'd3, 8'd2,    8'd2,    2'd3},
    {2'd0, 8'h1F,   8'h10,   2'd0},
    {2'd1, 8'd7,    8'd7,    2'd3},
    {2'd0, 8'd3,    8'd4,    2'd0}
  };

  task automatic chk(input string what, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int unit_of(input logic [1:0] p);
    return (p == 2'd0) ? 1 : (p == 2'd1) ? 4 : 16;
  endfunction

  task automatic configure(input logic [1:0] p, input logic [7:0] pr,
                           input logic [7:0] dh, input logic [1:0] dl);
    @(negedge clk);
    mod_en = 1'b0;
    presc_sel = p;
    period_we = 1'b1; period_wdata = pr;
    duty_hi_we = 1'b1; duty_hi_wdata = dh;
    duty_lo_we = 1'b1; duty_lo_wdata = dl;
    @(negedge clk);
    period_we = 1'b0; duty_hi_we = 1'b0; duty_lo_we = 1'b0;
    @(negedge clk);
  endtask

  // Raises mod_en at a negedge, returns negedges until pwm_out is seen high.
  task automatic enable_and_wait(input int limit, output int cnt);
    mod_en = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!pwm_out && cnt < limit);
  endtask

  task automatic wait_rise(input int limit, output bit found);
    logic prev;
    prev = pwm_out;
    found = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (pwm_out && !prev) begin found = 1; break; end
      prev = pwm_out;
    end
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (pwm_out && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, hi, per, full, d, unt, exp_hi;
    bit found;
    logic last;
    rst_n = 1'b0; mod_en = 1'b0; tmr_en = 1'b1; presc_sel = 2'd0;
    period_we = 1'b0; period_wdata = '0;
    duty_hi_we = 1'b0; duty_hi_wdata = '0;
    duty_lo_we = 1'b0; duty_lo_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pwm_out at reset", pwm_out == 1'b0, pwm_out, 0);
    chk("R1 active_hi at reset", active_hi == 8'd0, active_hi, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table: frame length, high time, active duty view
    foreach (VEC[k]) begin
      configure(VEC[k][19:18], VEC[k][17:10], VEC[k][9:2], VEC[k][1:0]);
      unt    = unit_of(VEC[k][19:18]);
      full   = (int'(VEC[k][17:10]) + 1) * 4;
      per    = full * unt;
      d      = int'(VEC[k][9:0]);
      exp_hi = ((d >= full) ? full : d) * unt;
      // R9 active copy followed writes while disabled
      chk("R9 active_hi while disabled", active_hi == VEC[k][9:2], active_hi, int'(VEC[k][9:2]));
      enable_and_wait(per + 10, n);
      // R7 prescale selects first-frame latency
      chk("R7/R8 first frame latency", n == per, n, per);
      hi = 0; last = 1'b0;
      for (int i = 0; i < per; i++) begin
        if (pwm_out) hi++;
        last = pwm_out;
        @(negedge clk);
      end
      if (d >= full) chk("R5 full-frame high", hi == exp_hi, hi, exp_hi);
      else           chk("R3 high time", hi == exp_hi, hi, exp_hi);
      chk("R2 next frame start", pwm_out && (d >= full || !last), int'(pwm_out), 1);
    end

    // R6 zero duty never drives high
    configure(2'd0, 8'd3, 8'd0, 2'd0);
    mod_en = 1'b1;
    hi = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
    chk("R6 zero duty high count", hi == 0, hi, 0);

    // R4 write during a frame is deferred (D=8 active, write D=20)
    configure(2'd0, 8'd9, 8'd2, 2'd0);
    enable_and_wait(100, n);
    duty_hi_we = 1'b1; duty_hi_wdata = 8'd5;
    duty_lo_we = 1'b1; duty_lo_wdata = 2'd0;
    count_high(hi);
    duty_hi_we = 1'b0; duty_lo_we = 1'b0;
    chk("R4 active_hi mid frame", active_hi == 8'd2, active_hi, 2);
    chk("R4 high time of frame with write", hi == 8, hi, 8);
    wait_rise(100, found);
    chk("R4 active_hi after boundary", found && active_hi == 8'd5, active_hi, 5);
    count_high(hi);
    chk("R4 new high time", hi == 20, hi, 20);

    // R10 timer stop stretches the high phase (D=30, 20 stopped clocks)
    configure(2'd0, 8'd9, 8'd7, 2'd2);
    enable_and_wait(100, n);
    repeat (4) @(negedge clk);
    tmr_en = 1'b0;
    repeat (20) @(negedge clk);
    tmr_en = 1'b1;
    count_high(hi);
    chk("R10 stretched high time", hi + 24 == 50, hi + 24, 50);

    // R8 disable mid-high clears output and counters
    configure(2'd1, 8'd2, 8'd4, 2'd0);
    enable_and_wait(200, n);
    @(negedge clk);
    mod_en = 1'b0;
    @(negedge clk);
    chk("R8 output low after disable", pwm_out == 1'b0, pwm_out, 0);
    @(negedge clk);
    enable_and_wait(200, n);
    chk("R8 latency after re-enable", n == 48, n, 48);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule